// File: doc/BRIEF.md
# Per-Line L1 Coherence Controller with Core Squash Notice

This block holds the coherence state of one L1 cache line in a directory-based MESI system. It takes fills and local store hits from the cache pipeline, local eviction requests, and two kinds of request from the shared level: invalidations and forwarded requests for exclusive ownership. It walks the line through Invalid, Shared, Exclusive, Modified and a write-back-pending state. It emits invalidation acknowledgements, dirty data, write-back (PUTX) messages and data replies to a requesting peer. A single transaction buffer keeps the evicted line's address and data while a write-back is in flight.

Whenever the core's copy of the line is taken away, the block can tell the core so that speculatively executed loads of that line are squashed. This notice is a one-cycle pulse carrying the line address. A configuration input enables it. The tag lookup, data array, network and the core's reaction to the notice lie outside the block. Line data is read from the array through `line_data`.

Top module: `coh_l1_line_ctrl`

## Requirements
- R1: After reset the state reads Invalid (`state_o` = 0). No squash, message or pop is raised until an event arrives. States are encoded I=0, S=1, E=2, M=3, write-back pending=4.
- R2: In Invalid, a fill moves the line to S (`fill_excl`=0) or E (`fill_excl`=1) and records `fill_addr`. A store hit in E moves the line to M.
- R3: An eviction of a line in S moves it to Invalid and sends no message on either channel.
- R4: An invalidation of a line in S pops the request, moves to Invalid and, one cycle later, sends an acknowledgement on the L2 channel (`l2_kind`=0) carrying the line address.
- R5: An eviction of a line in E or M moves to write-back pending and captures the line address and data in the buffer. Two cycles later it sends PUTX (`net_kind`=0) with that data on the message channel.
- R6: An invalidation of a line in E sends a data-free acknowledgement (`l2_kind`=0). In M it sends the line data to L2 (`l2_kind`=1). Either way it pops the request, moves to Invalid, and the L2 message appears one cycle after the event.
- R7: A forwarded exclusive request to a line in E or M pops the request and moves to Invalid. Two cycles later it sends the line data (`net_kind`=1) to the requester named by `fwd_src`.
- R8: Each transition in R3 to R7 that leaves S, E or M raises `squash_vld` in the same cycle as the event, with `squash_addr` set to the line address. This happens only while `squash_en` is 1. No other event raises it.
- R9: In write-back pending, a forwarded request is answered from the buffer and an invalidation sends the buffered data to L2. Both pop the request and keep the state. A write-back acknowledgement returns the line to Invalid.
- R10: Events presented together are served one per cycle, highest first: invalidation, forwarded request, write-back acknowledgement, eviction, fill, store hit. Lower events in that cycle are dropped. `req_pop` is raised only when an invalidation or forwarded request is served.
- R11: In Invalid, an invalidation is still acknowledged and popped without a squash. An eviction in Invalid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| squash_en | input | 1 | Enables the squash notice to the core |
| fill_vld | input | 1 | Line fill completed |
| fill_excl | input | 1 | Fill grants exclusive (E) rather than shared |
| fill_addr | input | AW | Address of the filled line |
| store_hit | input | 1 | Local store hit on the line |
| line_data | input | DW | Current line contents from the data array |
| repl_vld | input | 1 | Local eviction request |
| inv_vld | input | 1 | Invalidation from the shared level |
| fwd_vld | input | 1 | Forwarded exclusive-ownership request |
| fwd_src | input | IW | Requester of the forwarded request |
| wback_ack | input | 1 | Write-back acknowledged by L2 |
| state_o | output | 3 | Current coherence state |
| req_pop | output | 1 | Incoming request consumed this cycle |
| squash_vld | output | 1 | Squash notice to the core |
| squash_addr | output | AW | Line address of the squash notice |
| l2_vld | output | 1 | Message to L2 valid |
| l2_kind | output | 1 | 0 acknowledgement, 1 data |
| l2_addr | output | AW | Line address of the L2 message |
| l2_data | output | DW | Data of the L2 message |
| net_vld | output | 1 | Request/response message valid |
| net_kind | output | 1 | 0 PUTX, 1 data to requester |
| net_dest | output | IW | Destination requester for data replies |
| net_addr | output | AW | Line address of the message |
| net_data | output | DW | Data of the message |

## Verification
The hardest situation to reach is a forwarded request or invalidation that lands while a write-back is still pending. The reply must then come from the buffer and not from the array, and no squash may fire. The bench evicts a Modified line and then changes `line_data`. It presents a forwarded request and an invalidation before sending the write-back acknowledgement, so that a reply drawn from the array would show up as a data mismatch. Same-cycle collisions of invalidation, forward and eviction are also driven together to expose the service order.

// File: rtl/l1c_pkg.sv
// Shared types for the per-line L1 coherence controller.
// Assumes one line and one event served per cycle.
package l1c_pkg;

    typedef enum logic [2:0] {
        ST_I  = 3'd0,
        ST_S  = 3'd1,
        ST_E  = 3'd2,
        ST_M  = 3'd3,
        ST_MI = 3'd4
    } lstate_t;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_INV   = 3'd1,
        EV_FWD   = 3'd2,
        EV_WBACK = 3'd3,
        EV_REPL  = 3'd4,
        EV_FILL  = 3'd5,
        EV_STORE = 3'd6
    } levent_t;

    localparam logic L2_ACK   = 1'b0;
    localparam logic L2_DATA  = 1'b1;
    localparam logic NET_PUTX = 1'b0;
    localparam logic NET_DATA = 1'b1;

    typedef struct packed {
        logic squash;
        logic pop;
        logic l2_send;
        logic l2_kind;
        logic l2_from_tbe;
        logic net_send;
        logic net_kind;
        logic net_from_tbe;
        logic tbe_alloc;
        logic capture_addr;
    } lact_t;

endpackage

// File: rtl/l1c_event_sel.sv
// Event selector: picks the single event served this cycle by fixed priority.
// Assumes requesters hold dropped events and present them again.
module l1c_event_sel
    import l1c_pkg::*;
(
    input  logic    inv_vld,
    input  logic    fwd_vld,
    input  logic    wback_ack,
    input  logic    repl_vld,
    input  logic    fill_vld,
    input  logic    store_hit,
    output levent_t ev_o
);

    // Priority chain: requests from the shared level ahead of local activity.
    always_comb begin
        if (inv_vld)        ev_o = EV_INV;
        else if (fwd_vld)   ev_o = EV_FWD;
        else if (wback_ack) ev_o = EV_WBACK;
        else if (repl_vld)  ev_o = EV_REPL;
        else if (fill_vld)  ev_o = EV_FILL;
        else if (store_hit) ev_o = EV_STORE;
        else                ev_o = EV_NONE;
    end

endmodule

// File: rtl/l1c_fsm.sv
// Coherence state register and per-event action decode for one line.
// Assumes one event per cycle; actions are valid in the cycle of the event.
module l1c_fsm
    import l1c_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    squash_en,
    input  levent_t ev_i,
    input  logic    fill_excl,
    output lstate_t state_o,
    output lact_t   act_o
);

    lstate_t state_q;
    lstate_t state_d;
    lact_t   act_raw;
    logic    leaving;

    // Next-state and action decode for the current state and event.
    always_comb begin
        act_raw = '0;
        state_d = state_q;
        leaving = 1'b0;
        unique case (state_q)
            ST_I: begin
                if (ev_i == EV_INV) begin
                    act_raw.pop     = 1'b1;
                    act_raw.l2_send = 1'b1;
                    act_raw.l2_kind = L2_ACK;
                end else if (ev_i == EV_FWD) begin
                    act_raw.pop = 1'b1;
                end else if (ev_i == EV_FILL) begin
                    act_raw.capture_addr = 1'b1;
                    state_d = fill_excl ? ST_E : ST_S;
                end
            end
            ST_S: begin
                if (ev_i == EV_INV) begin
                    leaving         = 1'b1;
                    act_raw.pop     = 1'b1;
                    act_raw.l2_send = 1'b1;
                    act_raw.l2_kind = L2_ACK;
                    state_d = ST_I;
                end else if (ev_i == EV_FWD) begin
                    act_raw.pop = 1'b1;
                end else if (ev_i == EV_REPL) begin
                    leaving = 1'b1;
                    state_d = ST_I;
                end
            end
            ST_E, ST_M: begin
                if (ev_i == EV_INV) begin
                    leaving         = 1'b1;
                    act_raw.pop     = 1'b1;
                    act_raw.l2_send = 1'b1;
                    act_raw.l2_kind = (state_q == ST_M) ? L2_DATA : L2_ACK;
                    state_d = ST_I;
                end else if (ev_i == EV_FWD) begin
                    leaving          = 1'b1;
                    act_raw.pop      = 1'b1;
                    act_raw.net_send = 1'b1;
                    act_raw.net_kind = NET_DATA;
                    state_d = ST_I;
                end else if (ev_i == EV_REPL) begin
                    leaving           = 1'b1;
                    act_raw.tbe_alloc = 1'b1;
                    act_raw.net_send  = 1'b1;
                    act_raw.net_kind  = NET_PUTX;
                    state_d = ST_MI;
                end else if (ev_i == EV_STORE && state_q == ST_E) begin
                    state_d = ST_M;
                end
            end
            ST_MI: begin
                if (ev_i == EV_INV) begin
                    act_raw.pop         = 1'b1;
                    act_raw.l2_send     = 1'b1;
                    act_raw.l2_kind     = L2_DATA;
                    act_raw.l2_from_tbe = 1'b1;
                end else if (ev_i == EV_FWD) begin
                    act_raw.pop          = 1'b1;
                    act_raw.net_send     = 1'b1;
                    act_raw.net_kind     = NET_DATA;
                    act_raw.net_from_tbe = 1'b1;
                end else if (ev_i == EV_WBACK) begin
                    state_d = ST_I;
                end
            end
            default: state_d = ST_I;
        endcase
    end

    // Gate the squash notice with the configuration enable.
    always_comb begin
        act_o        = act_raw;
        act_o.squash = leaving & squash_en;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_I;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    AST_SQUASH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        act_o.squash |=> (state_q == ST_I || state_q == ST_MI)); // R8
    AST_MI_EXIT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_MI && state_q != ST_MI) |-> $past(ev_i == EV_WBACK)); // R9

endmodule

// File: rtl/l1c_tbe.sv
// Single transaction buffer: keeps the evicted line's address and data.
// Assumes at most one write-back in flight (the state machine enforces it).
module l1c_tbe #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Capture on allocation, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (alloc) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    assign addr_o = addr_q;
    assign data_o = data_q;

endmodule

// File: rtl/l1c_delay.sv
// Fixed-latency message pipe modelling a network hop of LAT cycles.
// Assumes no backpressure; LAT of zero gives a wire.
module l1c_delay #(
    parameter int LAT = 1,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    generate
        if (LAT == 0) begin : g_wire
            assign out_vld  = in_vld;
            assign out_data = in_data;
        end else begin : g_pipe
            logic [LAT-1:0]        vld_q;
            logic [LAT-1:0][W-1:0] dat_q;

            // Shift valid bits, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                end else begin
                    vld_q[0] <= in_vld;
                    for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
                end
            end

            // Shift payloads alongside the valid bits.
            always_ff @(posedge clk) begin
                dat_q[0] <= in_data;
                for (int i = 1; i < LAT; i++) dat_q[i] <= dat_q[i-1];
            end

            assign out_vld  = vld_q[LAT-1];
            assign out_data = dat_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/coh_l1_line_ctrl.sv
// Per-line L1 MESI controller with an optional squash notice to the core.
// Assumes the data array supplies line_data and that messages are never stalled.
module coh_l1_line_ctrl
    import l1c_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 64,
    parameter int IW      = 4,
    parameter int MSG_LAT = 2,
    parameter int L2_LAT  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          squash_en,
    input  logic          fill_vld,
    input  logic          fill_excl,
    input  logic [AW-1:0] fill_addr,
    input  logic          store_hit,
    input  logic [DW-1:0] line_data,
    input  logic          repl_vld,
    input  logic          inv_vld,
    input  logic          fwd_vld,
    input  logic [IW-1:0] fwd_src,
    input  logic          wback_ack,
    output logic [2:0]    state_o,
    output logic          req_pop,
    output logic          squash_vld,
    output logic [AW-1:0] squash_addr,
    output logic          l2_vld,
    output logic          l2_kind,
    output logic [AW-1:0] l2_addr,
    output logic [DW-1:0] l2_data,
    output logic          net_vld,
    output logic          net_kind,
    output logic [IW-1:0] net_dest,
    output logic [AW-1:0] net_addr,
    output logic [DW-1:0] net_data
);

    localparam int L2W  = 1 + AW + DW;
    localparam int NETW = 1 + IW + AW + DW;

    levent_t       ev;
    lstate_t       state;
    lact_t         act;
    logic [AW-1:0] line_addr_q;
    logic [AW-1:0] tbe_addr;
    logic [DW-1:0] tbe_data;
    logic [L2W-1:0]  l2_in;
    logic [L2W-1:0]  l2_out;
    logic [NETW-1:0] net_in;
    logic [NETW-1:0] net_out;

    l1c_event_sel u_sel (
        .inv_vld   (inv_vld),
        .fwd_vld   (fwd_vld),
        .wback_ack (wback_ack),
        .repl_vld  (repl_vld),
        .fill_vld  (fill_vld),
        .store_hit (store_hit),
        .ev_o      (ev)
    );

    l1c_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .squash_en (squash_en),
        .ev_i      (ev),
        .fill_excl (fill_excl),
        .state_o   (state),
        .act_o     (act)
    );

    // Line address register, loaded on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                line_addr_q <= '0;
        else if (act.capture_addr) line_addr_q <= fill_addr;
    end

    l1c_tbe #(.AW(AW), .DW(DW)) u_tbe (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (act.tbe_alloc),
        .addr_i (line_addr_q),
        .data_i (line_data),
        .addr_o (tbe_addr),
        .data_o (tbe_data)
    );

    // Build message payloads from the line or from the buffer.
    always_comb begin
        l2_in  = {act.l2_kind,
                  act.l2_from_tbe ? tbe_addr : line_addr_q,
                  act.l2_from_tbe ? tbe_data : line_data};
        net_in = {act.net_kind,
                  (act.net_kind == NET_DATA) ? fwd_src : {IW{1'b0}},
                  act.net_from_tbe ? tbe_addr : line_addr_q,
                  act.net_from_tbe ? tbe_data : line_data};
    end

    l1c_delay #(.LAT(L2_LAT), .W(L2W)) u_l2_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (act.l2_send),
        .in_data  (l2_in),
        .out_vld  (l2_vld),
        .out_data (l2_out)
    );

    l1c_delay #(.LAT(MSG_LAT), .W(NETW)) u_net_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (act.net_send),
        .in_data  (net_in),
        .out_vld  (net_vld),
        .out_data (net_out)
    );

    assign {l2_kind, l2_addr, l2_data}            = l2_out;
    assign {net_kind, net_dest, net_addr, net_data} = net_out;
    assign state_o     = state;
    assign req_pop     = act.pop;
    assign squash_vld  = act.squash;
    assign squash_addr = line_addr_q;

    AST_POP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_pop |-> (inv_vld || fwd_vld)); // R10
    AST_NO_SQUASH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_en |-> !squash_vld); // R8
    AST_S_EVICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && repl_vld && !inv_vld && !fwd_vld && !wback_ack) |=> !l2_vld); // R3
    AST_MI_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> !squash_vld); // R9

endmodule

// File: tb/sim_coh_l1_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_l1_line_ctrl;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          squash_en = 1'b1;
    logic          fill_vld = 1'b0, fill_excl = 1'b0, store_hit = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] line_data = '0;
    logic          repl_vld = 1'b0, inv_vld = 1'b0, fwd_vld = 1'b0, wback_ack = 1'b0;
    logic [IW-1:0] fwd_src = '0;
    logic [2:0]    state_o;
    logic          req_pop, squash_vld, l2_vld, l2_kind, net_vld, net_kind;
    logic [AW-1:0] squash_addr, l2_addr, net_addr;
    logic [DW-1:0] l2_data, net_data;
    logic [IW-1:0] net_dest;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    coh_l1_line_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .squash_en(squash_en),
        .fill_vld(fill_vld), .fill_excl(fill_excl), .fill_addr(fill_addr),
        .store_hit(store_hit), .line_data(line_data), .repl_vld(repl_vld),
        .inv_vld(inv_vld), .fwd_vld(fwd_vld), .fwd_src(fwd_src),
        .wback_ack(wback_ack), .state_o(state_o), .req_pop(req_pop),
        .squash_vld(squash_vld), .squash_addr(squash_addr),
        .l2_vld(l2_vld), .l2_kind(l2_kind), .l2_addr(l2_addr), .l2_data(l2_data),
        .net_vld(net_vld), .net_kind(net_kind), .net_dest(net_dest),
        .net_addr(net_addr), .net_data(net_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        fill_vld = 0; store_hit = 0; repl_vld = 0; inv_vld = 0;
        fwd_vld = 0; wback_ack = 0;
    endtask

    // Fill the line in I, then check the resulting state.
    task automatic fill_line(input logic [AW-1:0] a, input logic excl, input logic [2:0] st);
        @(negedge clk); fill_vld = 1; fill_excl = excl; fill_addr = a;
        @(negedge clk); clear_in();
        chk("R2 fill state", state_o, st);
    endtask

    task automatic to_modified(input logic [AW-1:0] a);
        fill_line(a, 1'b1, 3'd2);
        @(negedge clk); store_hit = 1;
        @(negedge clk); clear_in();
        chk("R2 store E->M", state_o, 3'd3);
    endtask

    task automatic t_reset();
        chk("R1 reset state", state_o, 3'd0);
        chk("R1 no l2 msg", l2_vld, 0);
        chk("R1 no net msg", net_vld, 0);
        chk("R1 no squash", squash_vld, 0);
        chk("R1 no pop", req_pop, 0);
    endtask

    task automatic t_s_evict();
        fill_line(16'h1234, 1'b0, 3'd1);
        @(negedge clk); repl_vld = 1; #1;
        chk("R8 squash on S evict", squash_vld, 1);
        chk("R8 squash addr", squash_addr, 16'h1234);
        @(negedge clk); clear_in();
        chk("R3 S evict state", state_o, 3'd0);
        chk("R3 no l2 msg", l2_vld, 0);
        @(negedge clk);
        chk("R3 no net msg", net_vld, 0);
    endtask

    task automatic t_s_inv();
        fill_line(16'h2222, 1'b0, 3'd1);
        @(negedge clk); inv_vld = 1; #1;
        chk("R4 pop", req_pop, 1);
        chk("R8 squash on S inv", squash_vld, 1);
        @(negedge clk); clear_in();
        chk("R4 state", state_o, 3'd0);
        chk("R4 ack valid", l2_vld, 1);
        chk("R4 ack kind", l2_kind, 0);
        chk("R4 ack addr", l2_addr, 16'h2222);
    endtask

    task automatic t_e_inv();
        fill_line(16'h3333, 1'b1, 3'd2);
        @(negedge clk); inv_vld = 1; #1;
        chk("R8 squash on E inv", squash_vld, 1);
        @(negedge clk); clear_in();
        chk("R6 E inv state", state_o, 3'd0);
        chk("R6 E inv ack", {l2_vld, l2_kind}, 2'b10);
    endtask

    task automatic t_m_inv();
        to_modified(16'h4444);
        line_data = 32'hD00D_0001;
        @(negedge clk); inv_vld = 1; #1;
        chk("R6 M inv pop", req_pop, 1);
        @(negedge clk); clear_in();
        chk("R6 M inv state", state_o, 3'd0);
        chk("R6 M inv data msg", {l2_vld, l2_kind}, 2'b11);
        chk("R6 M inv data", l2_data, 32'hD00D_0001);
    endtask

    task automatic t_e_fwd();
        fill_line(16'h5555, 1'b1, 3'd2);
        line_data = 32'hAAAA_5555;
        @(negedge clk); fwd_vld = 1; fwd_src = 4'd5; #1;
        chk("R7 pop", req_pop, 1);
        chk("R8 squash on fwd", squash_vld, 1);
        @(negedge clk); clear_in();
        chk("R7 state", state_o, 3'd0);
        chk("R7 not early", net_vld, 0);
        @(negedge clk);
        chk("R7 data valid", {net_vld, net_kind}, 2'b11);
        chk("R7 dest", net_dest, 4'd5);
        chk("R7 data", net_data, 32'hAAAA_5555);
    endtask

    task automatic t_m_evict_pending();
        to_modified(16'h6666);
        line_data = 32'hBEEF_0006;
        @(negedge clk); repl_vld = 1; #1;
        chk("R8 squash on M evict", squash_vld, 1);
        @(negedge clk); clear_in();
        line_data = 32'h0BAD_0BAD;
        chk("R5 state pending", state_o, 3'd4);
        chk("R5 not early", net_vld, 0);
        @(negedge clk);
        chk("R5 putx", {net_vld, net_kind}, 2'b10);
        chk("R5 putx data", net_data, 32'hBEEF_0006);
        chk("R5 putx addr", net_addr, 16'h6666);
        // Forwarded request while the write-back is pending.
        @(negedge clk); fwd_vld = 1; fwd_src = 4'd3; #1;
        chk("R9 no squash in pending", squash_vld, 0);
        chk("R9 fwd pop", req_pop, 1);
        @(negedge clk); clear_in();
        chk("R9 stays pending", state_o, 3'd4);
        @(negedge clk);
        chk("R9 fwd reply", {net_vld, net_kind, net_dest}, {2'b11, 4'd3});
        chk("R9 reply from buffer", net_data, 32'hBEEF_0006);
        // Invalidation while pending.
        @(negedge clk); inv_vld = 1; #1;
        chk("R9 inv pop", req_pop, 1);
        @(negedge clk); clear_in();
        chk("R9 inv data to L2", {l2_vld, l2_kind}, 2'b11);
        chk("R9 inv buffered data", l2_data, 32'hBEEF_0006);
        chk("R9 still pending", state_o, 3'd4);
        @(negedge clk); wback_ack = 1;
        @(negedge clk); clear_in();
        chk("R9 ack returns to I", state_o, 3'd0);
    endtask

    task automatic t_squash_off();
        squash_en = 0;
        fill_line(16'h7777, 1'b1, 3'd2);
        @(negedge clk); inv_vld = 1; #1;
        chk("R8 squash disabled", squash_vld, 0);
        @(negedge clk); clear_in();
        chk("R8 inv still served", state_o, 3'd0);
        squash_en = 1;
    endtask

    task automatic t_priority();
        fill_line(16'h8888, 1'b1, 3'd2);
        @(negedge clk); inv_vld = 1; fwd_vld = 1; repl_vld = 1; fwd_src = 4'd9; #1;
        @(negedge clk); clear_in();
        chk("R10 inv wins state", state_o, 3'd0);
        chk("R10 inv wins ack", {l2_vld, l2_kind}, 2'b10);
        @(negedge clk);
        chk("R10 no net msg", net_vld, 0);
        to_modified(16'h9999);
        @(negedge clk); fwd_vld = 1; repl_vld = 1; fwd_src = 4'd2; #1;
        @(negedge clk); clear_in();
        chk("R10 fwd beats evict", state_o, 3'd0);
        @(negedge clk);
        chk("R10 data reply", {net_vld, net_kind, net_dest}, {2'b11, 4'd2});
    endtask

    task automatic t_invalid_events();
        @(negedge clk); repl_vld = 1; #1;
        chk("R11 evict in I no squash", squash_vld, 0);
        @(negedge clk); clear_in();
        chk("R11 evict in I stays", state_o, 3'd0);
        @(negedge clk); inv_vld = 1; #1;
        chk("R11 inv in I pop", req_pop, 1);
        chk("R11 inv in I no squash", squash_vld, 0);
        @(negedge clk); clear_in();
        chk("R11 inv in I ack", {l2_vld, l2_kind}, 2'b10);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_s_evict();
        t_s_inv();
        t_e_inv();
        t_m_inv();
        t_e_fwd();
        t_m_evict_pending();
        t_squash_off();
        t_priority();
        t_invalid_events();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule